// File: doc/BRIEF.md
# Flash Page Program Load Buffer

This block gathers the data bytes of one page-program command and turns them into a single self-timed program operation on an emulated flash array. The serial front end supplies four things: an address strobe with the starting address, a strobe with each received data byte, a pulse when chip select rises, and a flag that says whether that rise fell on a whole-byte boundary. The page number is taken from the upper address bits and the starting byte offset from the low eight bits. Each byte goes into a 256-entry staging buffer at a pointer that wraps inside the page. A per-offset mask records which entries were filled.

When chip select rises, the block commits the staged bytes if four conditions all hold: the transfer was byte-aligned, write enable is granted, the page is outside the protected range, and at least one byte was loaded. The enable and protection checks are made outside the block and arrive as qualifier inputs. During the commit, a sequencer walks the 256 offsets and writes each loaded byte into the array as old AND new, because programming can only clear bits. A busy counter holds the busy flag for a fixed number of system clocks to stand in for the program time. When busy ends, the block sends a one-cycle pulse that tells the status logic to clear its write-enable latch. The array is read through a plain combinational read port.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `busy` and `wel_clear` are 0 and every array byte reads 0xFF.
- R2: The page is `addr_in[ADDR_W-1:8]`. The first data byte lands at offset `addr_in[7:0]` and each following byte lands at the next offset.
- R3: The offset advances modulo 256, so a transfer that passes offset 255 continues at offset 0 of the same page and never touches another page.
- R4: When more than 256 bytes are loaded, each offset holds the last byte received for it, so the last 256 bytes are programmed.
- R5: Only offsets that received a byte are written at commit. All other bytes of the page and of the array keep their values.
- R6: A programmed byte becomes the old array value AND the loaded value.
- R7: A `cs_rise` with `byte_aligned`=0, or with no data byte loaded, starts no program: `busy` stays 0 and the array is unchanged.
- R8: A `cs_rise` with `wr_en_ok`=0 or `prot_ok`=0 starts no program: `busy` stays 0, no `wel_clear` pulse is issued, and the array is unchanged.
- R9: A committed program raises `busy` in the cycle after `cs_rise` and holds it for exactly max(`PROG_CYCLES`, 256) cycles (300 by default).
- R10: `wel_clear` is a one-cycle pulse in the first cycle after `busy` falls, and it appears at no other time.
- R11: While `busy` is 1, `addr_load`, `byte_valid` and `cs_rise` are ignored: the busy length and the programmed result are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Strobe: a page-program command latched `addr_in` |
| addr_in | input | ADDR_W | Page number (upper bits) and starting byte offset (low 8 bits) |
| byte_valid | input | 1 | Strobe: one complete data byte is on `byte_data` |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Pulse on the rising edge of chip select |
| byte_aligned | input | 1 | Chip select rose on a whole-byte boundary |
| wr_en_ok | input | 1 | Write-enable latch is set |
| prot_ok | input | 1 | Target page is not block-protected |
| busy | output | 1 | Program operation in progress |
| wel_clear | output | 1 | One-cycle pulse at program completion |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bound checker watches the busy handshake on every cycle. It confirms that busy starts only after a qualified byte-aligned chip-select rise, that an unaligned or unqualified rise leaves the block idle, that every busy window has the exact length, and that the completion pulse sits right after busy falls and lasts one cycle. The data path can only be shown by the bench scenarios, which read the whole array back after each command. These scenarios cover offset wrap within a page, keep-last-256 on overflow, the untouched offsets, AND accumulation across repeated programs, and the stimulus that is ignored during busy.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    localparam int BYTE_W     = 8;
    localparam int OFF_W      = 8;
    localparam int PAGE_BYTES = 1 << OFF_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic [1:0] {
        PPB_IDLE = 2'd0,
        PPB_LOAD = 2'd1,
        PPB_PROG = 2'd2
    } ppb_state_e;

    // one array write produced by the commit walker
    typedef struct packed {
        logic  en;
        off_t  off;
        byte_t data;
    } ppb_wr_s;

    // busy window: never shorter than one walk over the page
    function automatic int busy_len(input int prog_cycles);
        return (prog_cycles > PAGE_BYTES) ? prog_cycles : PAGE_BYTES;
    endfunction

    function automatic logic commit_ok(input logic aligned, input logic wen,
                                       input logic unprot, input logic loaded);
        return aligned & wen & unprot & loaded;
    endfunction

endpackage

// File: rtl/ppb_load_buf.sv
module ppb_load_buf
    import ppb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  off_t  start_off,
    input  logic  wr,
    input  byte_t wr_data,
    input  off_t  rd_off,
    output byte_t rd_data,
    output logic  rd_mask,
    output logic  any_loaded
);

    byte_t                 stage [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    off_t                  ptr;

    // pointer and fill mask; pointer width makes the wrap modulo the page
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            ptr  <= '0;
        end else if (clear) begin
            mask <= '0;
            ptr  <= start_off;
        end else if (wr) begin
            mask[ptr] <= 1'b1;
            ptr       <= ptr + 1'b1;
        end
    end

    // staging storage: later bytes overwrite earlier ones at the same offset
    always_ff @(posedge clk) begin
        if (wr && !clear) begin
            stage[ptr] <= wr_data;
        end
    end

    assign rd_data    = stage[rd_off];
    assign rd_mask    = mask[rd_off];
    assign any_loaded = |mask;

endmodule

// File: rtl/ppb_prog_seq.sv
module ppb_prog_seq
    import ppb_pkg::*;
#(
    parameter int BUSY_CYCLES = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic walk_valid,
    output off_t walk_off,
    output logic done
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign done       = active && (cnt == CNT_W'(BUSY_CYCLES - 1));
    assign walk_valid = active && (cnt < CNT_W'(PAGE_BYTES));
    assign walk_off   = cnt[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (done) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppb_ctrl.sv
module ppb_ctrl
    import ppb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_load,
    input  logic cs_rise,
    input  logic byte_aligned,
    input  logic wr_en_ok,
    input  logic prot_ok,
    input  logic any_loaded,
    input  logic prog_done,
    output logic start_load,
    output logic start_prog,
    output logic loading,
    output logic busy,
    output logic wel_clear
);

    ppb_state_e state, state_nx;

    always_comb begin
        state_nx   = state;
        start_load = 1'b0;
        start_prog = 1'b0;
        unique case (state)
            PPB_IDLE: begin
                if (addr_load) begin
                    start_load = 1'b1;
                    state_nx   = PPB_LOAD;
                end
            end
            PPB_LOAD: begin
                if (cs_rise) begin
                    if (commit_ok(byte_aligned, wr_en_ok, prot_ok, any_loaded)) begin
                        start_prog = 1'b1;
                        state_nx   = PPB_PROG;
                    end else begin
                        state_nx = PPB_IDLE;
                    end
                end else if (addr_load) begin
                    start_load = 1'b1;
                end
            end
            PPB_PROG: begin
                if (prog_done) begin
                    state_nx = PPB_IDLE;
                end
            end
            default: state_nx = PPB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PPB_IDLE;
            wel_clear <= 1'b0;
        end else begin
            state     <= state_nx;
            wel_clear <= (state == PPB_PROG) && prog_done;
        end
    end

    assign loading = (state == PPB_LOAD);
    assign busy    = (state == PPB_PROG);

endmodule

// File: rtl/ppb_array.sv
module ppb_array
    import ppb_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W+OFF_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic [PAGE_W+OFF_W-1:0] rd_addr,
    output byte_t             rd_data
);

    localparam int DEPTH = 1 << (PAGE_W + OFF_W);

    byte_t cells [DEPTH];

    // erased cells read all ones; programming can only clear bits
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer
    import ppb_pkg::*;
#(
    parameter int PAGE_W      = 3,
    parameter int PROG_CYCLES = 300,
    localparam int ADDR_W     = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              byte_aligned,
    input  logic              wr_en_ok,
    input  logic              prot_ok,
    output logic              busy,
    output logic              wel_clear,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int BUSY_CYCLES = busy_len(PROG_CYCLES);

    logic              start_load, start_prog, loading;
    logic              any_loaded, seq_active, prog_done;
    logic              walk_valid;
    off_t              walk_off;
    byte_t             stage_byte;
    logic              stage_mask;
    logic [PAGE_W-1:0] page_r;
    ppb_wr_s           wr;

    ppb_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .addr_load    (addr_load),
        .cs_rise      (cs_rise),
        .byte_aligned (byte_aligned),
        .wr_en_ok     (wr_en_ok),
        .prot_ok      (prot_ok),
        .any_loaded   (any_loaded),
        .prog_done    (prog_done),
        .start_load   (start_load),
        .start_prog   (start_prog),
        .loading      (loading),
        .busy         (busy),
        .wel_clear    (wel_clear)
    );

    // page latched with the command; offset goes to the buffer pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            page_r <= '0;
        end else if (start_load) begin
            page_r <= addr_in[ADDR_W-1:OFF_W];
        end
    end

    ppb_load_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_load),
        .start_off  (addr_in[OFF_W-1:0]),
        .wr         (byte_valid && loading),
        .wr_data    (byte_data),
        .rd_off     (walk_off),
        .rd_data    (stage_byte),
        .rd_mask    (stage_mask),
        .any_loaded (any_loaded)
    );

    ppb_prog_seq #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_prog),
        .active     (seq_active),
        .walk_valid (walk_valid),
        .walk_off   (walk_off),
        .done       (prog_done)
    );

    always_comb begin
        wr.en   = seq_active && walk_valid && stage_mask;
        wr.off  = walk_off;
        wr.data = stage_byte;
    end

    ppb_array #(
        .PAGE_W (PAGE_W)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr.en),
        .wr_addr ({page_r, wr.off}),
        .wr_data (wr.data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk #(
    parameter int BUSY_CYCLES = 300
) (
    input logic clk,
    input logic rst,
    input logic cs_rise,
    input logic byte_aligned,
    input logic wr_en_ok,
    input logic prot_ok,
    input logic busy,
    input logic wel_clear
);

    int busy_run;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= 0;
        else     busy_run <= busy ? busy_run + 1 : 0;
    end

    // R1: reset leaves the block idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !wel_clear));

    // R7: an unaligned rise never starts a program
    assert_unaligned_no_prog_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !byte_aligned && !busy) |=> !busy);

    // R8: missing enable or protection blocks the program
    assert_unqualified_no_prog_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && (!wr_en_ok || !prot_ok) && !busy) |=> !busy);

    // R9: busy starts only after a qualified rise
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise && byte_aligned && wr_en_ok && prot_ok));

    // R9: busy window length
    assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == BUSY_CYCLES));

    // R9: busy never exceeds its window
    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < BUSY_CYCLES));

    // R10: completion pulse follows busy and lasts one cycle
    assert_wel_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wel_clear);

    assert_wel_only_then_R10: assert property (@(posedge clk) disable iff (rst)
        wel_clear |-> (!busy && $past(busy)));

    assert_wel_single_R10: assert property (@(posedge clk) disable iff (rst)
        wel_clear |=> !wel_clear);

endmodule

bind page_prog_buffer page_prog_buffer_chk #(
    .BUSY_CYCLES (ppb_pkg::busy_len(PROG_CYCLES))
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_rise      (cs_rise),
    .byte_aligned (byte_aligned),
    .wr_en_ok     (wr_en_ok),
    .prot_ok      (prot_ok),
    .busy         (busy),
    .wel_clear    (wel_clear)
);

// File: tb/page_prog_buffer_tb.sv
module page_prog_buffer_tb;

    localparam int PAGE_W   = 3;
    localparam int ADDR_W   = PAGE_W + 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PROG_CYC = 300;
    localparam int BUSY_EXP = 300;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              cs_rise = 1'b0;
    logic              byte_aligned = 1'b0;
    logic              wr_en_ok = 1'b0;
    logic              prot_ok = 1'b0;
    logic              busy;
    logic              wel_clear;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model   [DEPTH];
    logic [7:0] payload [512];

    always #10 clk = ~clk;

    page_prog_buffer #(
        .PAGE_W      (PAGE_W),
        .PROG_CYCLES (PROG_CYC)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .addr_load    (addr_load),
        .addr_in      (addr_in),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .cs_rise      (cs_rise),
        .byte_aligned (byte_aligned),
        .wr_en_ok     (wr_en_ok),
        .prot_ok      (prot_ok),
        .busy         (busy),
        .wel_clear    (wel_clear),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // full array read-back against the model
    task automatic compare_array(input string req);
        int mism = 0;
        int first = -1;
        int fa = 0, fe = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = ADDR_W'(a);
            #1;
            if (rd_data !== model[a]) begin
                mism++;
                if (first < 0) begin
                    first = a;
                    fa = int'(rd_data);
                    fe = int'(model[a]);
                end
            end
        end
        check(mism == 0, req, $sformatf("array byte @%0h", first), fa, fe);
    endtask

    // one page-program command; inject drives stimulus during busy
    task automatic run_cmd(input int page, input int off, input int n,
                           input bit aligned, input bit we, input bit po,
                           input bit inject, input string req);
        bit          commit;
        int          bcnt;
        logic [7:0]  last [256];
        bit          hit  [256];
        commit = aligned && we && po && (n > 0);
        @(negedge clk);
        addr_load = 1'b1;
        addr_in   = ADDR_W'((page << 8) | off);
        @(negedge clk);
        addr_load = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_valid = 1'b1;
            byte_data  = payload[k];
            @(negedge clk);
        end
        byte_valid   = 1'b0;
        byte_aligned = aligned;
        wr_en_ok     = we;
        prot_ok      = po;
        cs_rise      = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        bcnt = 0;
        while (busy === 1'b1 && bcnt < 2000) begin
            bcnt++;
            if (inject) begin
                addr_load  = (bcnt == 5);
                addr_in    = ADDR_W'(((page + 1) % 8) << 8);
                byte_valid = (bcnt == 6) || (bcnt == 7);
                byte_data  = 8'h00;
                cs_rise    = (bcnt == 8);
            end
            @(negedge clk);
        end
        addr_load = 1'b0; byte_valid = 1'b0; cs_rise = 1'b0;
        check(bcnt == (commit ? BUSY_EXP : 0), req, "busy cycles", bcnt,
              commit ? BUSY_EXP : 0);
        check(wel_clear === commit, "R10", "wel_clear after busy",
              int'(wel_clear), int'(commit));
        @(negedge clk);
        check(wel_clear === 1'b0 && busy === 1'b0, "R10", "wel_clear one cycle",
              int'(wel_clear), 0);
        if (commit) begin
            for (int o = 0; o < 256; o++) hit[o] = 1'b0;
            for (int k = 0; k < n; k++) begin
                last[(off + k) % 256] = payload[k];
                hit[(off + k) % 256]  = 1'b1;
            end
            for (int o = 0; o < 256; o++)
                if (hit[o]) model[page * 256 + o] = model[page * 256 + o] & last[o];
        end
        compare_array(req);
    endtask

    task automatic fill_payload(input int n, input int base);
        for (int k = 0; k < n; k++) payload[k] = 8'((base + k * 37) ^ (k >> 3));
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && wel_clear === 1'b0, "R1", "busy/wel after reset",
              int'({busy, wel_clear}), 0);
        compare_array("R1");

        // R2, R5: short transfer in the middle of page 2
        fill_payload(4, 8'h5A);
        run_cmd(2, 100, 4, 1, 1, 1, 0, "R2");

        // R3: wrap from offset 250 within page 5
        fill_payload(12, 8'hC3);
        run_cmd(5, 250, 12, 1, 1, 1, 0, "R3");

        // R4: 260 bytes, last 256 kept
        fill_payload(260, 8'h11);
        run_cmd(1, 5, 260, 1, 1, 1, 0, "R4");

        // R6: AND accumulation on the same bytes
        for (int k = 0; k < 3; k++) payload[k] = 8'hF0;
        run_cmd(6, 0, 3, 1, 1, 1, 0, "R6");
        for (int k = 0; k < 3; k++) payload[k] = 8'h3C;
        run_cmd(6, 0, 3, 1, 1, 1, 0, "R6");

        // R7: unaligned rise and empty transfer
        fill_payload(8, 8'h00);
        run_cmd(3, 0, 8, 0, 1, 1, 0, "R7");
        run_cmd(3, 0, 0, 1, 1, 1, 0, "R7");

        // R8: missing write enable, then protected page
        run_cmd(4, 16, 8, 1, 0, 1, 0, "R8");
        run_cmd(4, 16, 8, 1, 1, 0, 0, "R8");

        // R11: stimulus during busy is ignored
        fill_payload(6, 8'hE7);
        run_cmd(7, 40, 6, 1, 1, 1, 1, "R11");

        // mixed random commands (R2 R3 R4 R5 R6 R7)
        for (int it = 0; it < 10; it++) begin
            int n   = 1 + int'($urandom_range(299));
            int pg  = int'($urandom_range(7));
            int off = int'($urandom_range(255));
            bit al  = ($urandom_range(9) != 0);
            for (int k = 0; k < n; k++) payload[k] = 8'($urandom);
            run_cmd(pg, off, n, al, 1, 1, 0, "R5");
        end

        finish_run();
    end

endmodule